// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block keeps the time of day and the calendar date as packed BCD fields: seconds, minutes, hours, day of week, date, month and a two-digit year. It advances by one second on each cycle where a one-pulse-per-second enable is high. That enable is produced outside the block from a 32.768 kHz timebase. Carries ripple from seconds up to the year. The last date of each month is corrected for 30-day months and for February, including leap years.

The hours field carries its own format selection. One bit picks either 12-hour counting with an AM/PM flag or 24-hour counting. A host reaches every field through a small register-bank port: writes land on the next clock edge, and reads are combinational. One cycle after each one-second update, the block emits a single-cycle tick. Alarm comparators can sample the fields on that tick and know the values are settled.

Top module: `bcd_rtc_calendar`

## Requirements
- R1: After reset the fields read seconds 00, minutes 00, hours 00 in 24-hour mode, day of week 01, date 01, month 01, year 00, and tick_o is low.
- R2: Seconds and minutes count in BCD from 00 to 59. Seconds 59 wraps to 00 and advances minutes. Minutes 59 wraps to 00 and advances hours.
- R3: With hours bit 6 at 0 (24-hour mode), bits 5:4 hold the tens digit and bits 3:0 the ones digit, counting 00 to 23. Hour 23 wraps to 00 and advances to the next day.
- R4: With hours bit 6 at 1 (12-hour mode), bit 5 is PM (1) or AM (0), and bits 4:0 count BCD 01 to 12. 11 becomes 12 and toggles PM. 12 becomes 01 and keeps the flag. Only 11 PM to 12 AM advances to the next day.
- R5: Day of week counts 01 to 07 and wraps from 07 to 01 at each day rollover.
- R6: Date wraps to 01 and advances the month after 30 in months 04, 06, 09 and 11, after 31 in the other months, and after 28 or 29 in month 02.
- R7: February has 29 days when the year value is divisible by four (00 included), and 28 otherwise.
- R8: Month 12 wraps to 01 and advances the year. Year 99 wraps to 00.
- R9: Field addresses are 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year. Address 7 reads 00 and writes to it have no effect. Bits outside each field's mask read 0 whatever was written. The masks are 7F, 7F, 7F, 07, 3F, 1F and FF.
- R10: A host write is visible after the next clock edge. A field written in the same cycle as a one-second advance takes the written value and passes no carry upward. The other fields count as usual.
- R11: tick_o is high for exactly one cycle, the cycle after each edge where sec_en_i was high, and is low otherwise.
- R12: Without sec_en_i and without writes, no field changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sec_en_i | input | 1 | One-second advance enable, one cycle wide |
| wr_en_i | input | 1 | Host write strobe |
| addr_i | input | 3 | Field address |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Selected field, unused bits zero |
| tick_o | output | 1 | Pulse one cycle after each second update |

## Verification
The bench runs a little over an hour second by second against an arithmetic time model. It then places the clock at 23:59:59 on the last day of every month across four years, including 00, 24 and 99. A wrong month-length table or leap rule would show up as a date of 31 or 32, or as a February that skips the 29th. It also places every hour of the day at 59:59 in both hour modes. A 12-hour counter that toggles the flag on 12→01, or that advances the date at noon, would disagree with the model. Writes that collide with a second update are checked for carry leakage into minutes or hours, and masked bits and the empty address are checked for zeros.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NUM_FLD = 7;
  localparam int AW      = 3;

  typedef enum logic [AW-1:0] {
    FLD_SEC = 3'd0, FLD_MIN = 3'd1, FLD_HOUR = 3'd2, FLD_DOW = 3'd3,
    FLD_DATE = 3'd4, FLD_MON = 3'd5, FLD_YEAR = 3'd6
  } rtc_fld_e;

  localparam logic [7:0] FLD_MASK [NUM_FLD] = '{8'h7F, 8'h7F, 8'h7F, 8'h07, 8'h3F, 8'h1F, 8'hFF};
  localparam logic [7:0] FLD_LO   [NUM_FLD] = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00};
  localparam logic [7:0] FLD_MAX  [NUM_FLD] = '{8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99};

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // two-digit year divisible by four: even tens need ones 0/4/8, odd tens need 2/6
  function automatic logic is_leap(input logic [7:0] y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  function automatic logic [7:0] month_last(input logic [7:0] m, input logic [7:0] y);
    case (m)
      8'h02:                      return is_leap(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field #(
  parameter logic [7:0] MASK = 8'hFF,
  parameter logic [7:0] LO   = 8'h00
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       inc_i,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  input  logic [7:0] max_i,
  output logic [7:0] val_o,
  output logic       carry_o
);
  import rtc_pkg::*;

  logic at_max;
  assign at_max  = (val_o == max_i);
  assign carry_o = inc_i & ~wr_i & at_max;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    val_o <= LO;
    else if (wr_i)  val_o <= wdata_i & MASK;
    else if (inc_i) val_o <= at_max ? LO : bcd_inc(val_o);
  end

  assert_field_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !wr_i) |=> $stable(val_o));
  // covers seconds/minutes (R2), date (R6) and month/year (R8)
  assert_field_wrap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !wr_i && val_o == max_i) |=> (val_o == LO));
  assert_field_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> ((val_o & ~MASK) == 8'h00));
endmodule

// File: rtl/rtc_hour_field.sv
module rtc_hour_field (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       inc_i,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] val_o,
  output logic       carry_o
);
  import rtc_pkg::*;

  logic       mode12, pm;
  logic [7:0] nxt, h12_inc, h24_inc;

  assign mode12  = val_o[6];
  assign pm      = val_o[5];
  assign h12_inc = bcd_inc({3'b000, val_o[4:0]});
  assign h24_inc = bcd_inc({2'b00, val_o[5:0]});

  always_comb begin
    if (mode12) begin
      if (val_o[4:0] == 5'h12)      nxt = {1'b0, 1'b1, pm, 5'h01};
      else if (val_o[4:0] == 5'h11) nxt = {1'b0, 1'b1, ~pm, 5'h12};
      else                          nxt = {1'b0, 1'b1, pm, h12_inc[4:0]};
    end else begin
      if (val_o[5:0] == 6'h23)      nxt = 8'h00;
      else                          nxt = {2'b00, h24_inc[5:0]};
    end
  end

  // day rolls only at 23->00 or 11 PM -> 12 AM
  assign carry_o = inc_i & ~wr_i &
                   (mode12 ? (pm && val_o[4:0] == 5'h11) : (val_o[5:0] == 6'h23));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    val_o <= 8'h00;
    else if (wr_i)  val_o <= wdata_i & FLD_MASK[FLD_HOUR];
    else if (inc_i) val_o <= nxt;
  end

  assert_h24_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !wr_i && val_o == 8'h23) |=> (val_o == 8'h00));
  assert_h12_noon_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !wr_i && val_o == 8'h51) |=> (val_o == 8'h72));
  assert_mode_keep_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(val_o[6]));
endmodule

// File: rtl/bcd_rtc_calendar.sv
module bcd_rtc_calendar
  import rtc_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sec_en_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o,
  output logic          tick_o
);
  localparam int NSLOT = 1 << AW;

  logic [7:0]         fld_val [NSLOT];
  logic [NUM_FLD-1:0] inc, carry, wr;
  logic [7:0]         date_max;

  assign date_max = month_last(fld_val[FLD_MON], fld_val[FLD_YEAR]);

  // carry chain: day rollover feeds both day of week and date
  assign inc[FLD_SEC]  = sec_en_i;
  assign inc[FLD_MIN]  = carry[FLD_SEC];
  assign inc[FLD_HOUR] = carry[FLD_MIN];
  assign inc[FLD_DOW]  = carry[FLD_HOUR];
  assign inc[FLD_DATE] = carry[FLD_HOUR];
  assign inc[FLD_MON]  = carry[FLD_DATE];
  assign inc[FLD_YEAR] = carry[FLD_MON];

  for (genvar i = 0; i < NUM_FLD; i++) begin : g_fld
    assign wr[i] = wr_en_i && (addr_i == AW'(i));
    if (i == FLD_HOUR) begin : g_hour
      rtc_hour_field u_hour (
        .clk_i, .rst_ni, .inc_i(inc[i]), .wr_i(wr[i]), .wdata_i,
        .val_o(fld_val[i]), .carry_o(carry[i])
      );
    end else begin : g_bcd
      rtc_bcd_field #(.MASK(FLD_MASK[i]), .LO(FLD_LO[i])) u_field (
        .clk_i, .rst_ni, .inc_i(inc[i]), .wr_i(wr[i]), .wdata_i,
        .max_i((i == FLD_DATE) ? date_max : FLD_MAX[i]),
        .val_o(fld_val[i]), .carry_o(carry[i])
      );
    end
  end

  for (genvar j = NUM_FLD; j < NSLOT; j++) begin : g_empty
    assign fld_val[j] = 8'h00;
  end

  assign rdata_o = fld_val[addr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tick_o <= 1'b0;
    else         tick_o <= sec_en_i;
  end

  assert_tick_after_update_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_en_i && !wr_en_i) |=> (tick_o && fld_val[FLD_SEC] != $past(fld_val[FLD_SEC])));
  assert_no_tick_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sec_en_i |=> !tick_o);
  assert_dow_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (carry[FLD_DOW]) |=> (fld_val[FLD_DOW] == 8'h01));
  assert_date_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc[FLD_DATE] && !wr[FLD_DATE] && fld_val[FLD_DATE] == date_max) |=> (fld_val[FLD_DATE] == 8'h01));
endmodule

// File: tb/tb_bcd_rtc_calendar.sv
`timescale 1ns/1ps
module tb_bcd_rtc_calendar;
  localparam real CLK_NS = 4.0;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sec_en = 1'b0, wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       tick;

  int checks = 0, errors = 0;
  int m_sec, m_min, m_hr, m_dow, m_date, m_mon, m_yr, m_mode;

  always #(CLK_NS/2) clk = ~clk;

  bcd_rtc_calendar dut (
    .clk_i(clk), .rst_ni(rst_n), .sec_en_i(sec_en), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .tick_o(tick)
  );

  function automatic logic [7:0] bcd(input int n);
    return 8'((n / 10) * 16 + (n % 10));
  endfunction

  function automatic logic [7:0] enc_hour(input int h, input int mode);
    int h12;
    if (mode == 0) return bcd(h);
    h12 = (h % 12 == 0) ? 12 : h % 12;
    return 8'h40 | (h >= 12 ? 8'h20 : 8'h00) | bcd(h12);
  endfunction

  function automatic int days_in(input int mo, input int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] exp_fld(input int i);
    case (i)
      0: return bcd(m_sec);
      1: return bcd(m_min);
      2: return enc_hour(m_hr, m_mode);
      3: return bcd(m_dow);
      4: return bcd(m_date);
      5: return bcd(m_mon);
      6: return bcd(m_yr);
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input logic ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step();
    m_sec++;
    if (m_sec == 60) begin
      m_sec = 0; m_min++;
      if (m_min == 60) begin
        m_min = 0; m_hr++;
        if (m_hr == 24) begin
          m_hr = 0;
          m_dow = (m_dow % 7) + 1;
          m_date++;
          if (m_date > days_in(m_mon, m_yr)) begin
            m_date = 1; m_mon++;
            if (m_mon == 13) begin m_mon = 1; m_yr = (m_yr + 1) % 100; end
          end
        end
      end
    end
  endtask

  // reads all slots; called just after a falling edge
  task automatic compare(input string req);
    for (int i = 0; i < 8; i++) begin
      addr = 3'(i);
      #0.2;
      chk(rdata == exp_fld(i), req, rdata, exp_fld(i));
    end
  endtask

  task automatic host_wr(input int a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = 3'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_tick(input string req);
    @(negedge clk);
    sec_en = 1'b1;
    @(negedge clk);
    sec_en = 1'b0;
    chk(tick == 1'b1, "R11", {7'd0, tick}, 8'h01);
    model_step();
    compare(req);
  endtask

  task automatic set_state(input int s, input int mi, input int h, input int mode,
                           input int dw, input int dt, input int mo, input int yr);
    m_sec = s; m_min = mi; m_hr = h; m_mode = mode; m_dow = dw; m_date = dt; m_mon = mo; m_yr = yr;
    host_wr(6, bcd(yr));
    host_wr(5, bcd(mo));
    host_wr(4, bcd(dt));
    host_wr(3, bcd(dw));
    host_wr(2, enc_hour(h, mode));
    host_wr(1, bcd(mi));
    host_wr(0, bcd(s));
  endtask

  initial begin
    #(CLK_NS * 190000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int yrs[4] = '{23, 24, 0, 99};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    m_sec = 0; m_min = 0; m_hr = 0; m_mode = 0; m_dow = 1; m_date = 1; m_mon = 1; m_yr = 0;
    chk(tick == 1'b0, "R1", {7'd0, tick}, 8'h00);
    compare("R1");

    // R2: seconds and minutes over one hour and beyond
    for (int k = 0; k < 3700; k++) do_tick("R2");

    // R12: idle holds every field, tick stays low
    repeat (10) @(negedge clk);
    chk(tick == 1'b0, "R12", {7'd0, tick}, 8'h00);
    compare("R12");

    // R3: every hour of the day at xx:59:59 in 24-hour mode
    for (int h = 0; h < 24; h++) begin
      set_state(59, 59, h, 0, 3, 15, 6, 24);
      do_tick("R3");
    end
    // R4: same in 12-hour mode, day advances only at 11 PM
    for (int h = 0; h < 24; h++) begin
      set_state(59, 59, h, 1, 3, 15, 6, 24);
      do_tick("R4");
    end
    // R5: day-of-week rollover from each value
    for (int d = 1; d <= 7; d++) begin
      set_state(59, 59, 23, 0, d, 10, 3, 5);
      do_tick("R5");
    end
    // R6/R7/R8: last day and February 28 in several years
    foreach (yrs[y]) begin
      for (int mo = 1; mo <= 12; mo++) begin
        set_state(59, 59, 23, 0, 2, days_in(mo, yrs[y]), mo, yrs[y]);
        do_tick((mo == 12) ? "R8" : "R6");
      end
      set_state(59, 59, 11, 1, 2, 28, 2, yrs[y]);
      m_hr = 23; host_wr(2, enc_hour(23, 1));
      do_tick("R7");
    end

    // R10: write to minutes colliding with seconds rollover; write wins
    set_state(59, 5, 7, 0, 1, 1, 1, 0);
    @(negedge clk);
    sec_en = 1'b1; wr_en = 1'b1; addr = 3'd1; wdata = 8'h10;
    @(negedge clk);
    sec_en = 1'b0; wr_en = 1'b0;
    m_sec = 0; m_min = 10;
    compare("R10");
    // R10: write to seconds at 59 blocks carry into minutes and hours
    set_state(59, 59, 5, 0, 1, 1, 1, 0);
    @(negedge clk);
    sec_en = 1'b1; wr_en = 1'b1; addr = 3'd0; wdata = 8'h30;
    @(negedge clk);
    sec_en = 1'b0; wr_en = 1'b0;
    m_sec = 30;
    compare("R10");

    // R9: masked bits and empty slot read zero
    for (int a = 0; a < 8; a++) begin
      logic [7:0] mask;
      case (a)
        0, 1, 2: mask = 8'h7F;
        3:       mask = 8'h07;
        4:       mask = 8'h3F;
        5:       mask = 8'h1F;
        6:       mask = 8'hFF;
        default: mask = 8'h00;
      endcase
      host_wr(a, 8'hFF);
      addr = 3'(a);
      #0.2;
      chk(rdata == mask, "R9", rdata, mask);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule